// File: doc/BRIEF.md
# Fetch Miss Tracker with Request Merging

This block sits on the request side of an instruction fetch buffer. Each incoming fetch carries an address-space identifier and a byte address. The block aligns the address to a cache block and then looks for a match, first among its own outstanding block misses and then in an external table of blocks that are already buffered. A request that matches is merged, so no memory traffic results. A request that matches nothing starts one block-sized memory read and takes a pending-miss entry. Every entry keeps a count of the instructions waiting on its block.

Returned blocks are written into their pending entry, which then becomes valid. A completion port lets the consumer collect a valid block. The block leaves the tracker with its data and with the number of instructions still waiting, and the external buffer takes ownership of it. A squash removes one waiting instruction. It charges a buffered block first. If no buffered block matches, it charges the matching pending miss, and that miss is dropped once no instruction waits on it. The external buffered-block table is reached through combinational lookup outputs, lookup-hit inputs and count-update strobes.

Top module: `fetch_miss_merge`

## Requirements
- R1: Entries match only when both the identifier and the block address (byte address shifted right by log2 of the block size) are equal. Two byte addresses in the same block merge, and the same block under another identifier is a separate miss.
- R2: A request that matches a pending miss is accepted with `req_merged`=1 and no memory read, and that entry's waiting count rises by one.
- R3: The buffered table is consulted only while fewer than DEPTH misses are pending. On a hit (`buf_req_hit`=1, no pending match), `buf_inc` pulses, `req_merged`=1 and no read is issued.
- R4: With DEPTH misses pending and no pending match, `req_ready`=0 and the request causes no read, no merge and no `buf_inc`.
- R5: A true miss raises `mem_rd_valid` in the same cycle, with `mem_rd_addr` block-aligned (low log2(BLK_BYTES) bits zero) and `mem_rd_asid` equal to the request's. It allocates an entry with count 1 that is not yet valid.
- R6: A response with `rsp_squashed`=0 stores `rsp_data` into the matching pending entry and marks it valid at the next edge.
- R7: A response with `rsp_squashed`=1 changes no entry.
- R8: A squash with `buf_sq_hit`=1 pulses `buf_dec` and leaves pending entries unchanged. Otherwise the matching pending count falls by one, and the entry is freed at the edge where it reaches zero.
- R9: A fill request that matches a valid entry whose updated count is nonzero gives `fill_ok`=1, the stored block on `fill_data` and the updated count minus one on `fill_cnt`. The entry is freed at that edge.
- R10: After reset, no entry is allocated: `req_ready`=1 and `fill_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_asid | input | ASID_W | Request address-space identifier |
| req_addr | input | ADDR_W | Request byte address |
| req_merged | output | 1 | Accepted without a read; fill later from buffer |
| buf_req_blk | output | ADDR_W-log2(BLK_BYTES) | Block looked up in buffered table for the request |
| buf_req_hit | input | 1 | Buffered table holds (req_asid, buf_req_blk) |
| buf_inc | output | 1 | Increment waiting count of that buffered block |
| mem_rd_valid | output | 1 | Block read issued |
| mem_rd_asid | output | ASID_W | Identifier of the read |
| mem_rd_addr | output | ADDR_W | Block-aligned read address |
| rsp_valid | input | 1 | Block response present |
| rsp_asid | input | ASID_W | Response identifier |
| rsp_blk | input | ADDR_W-log2(BLK_BYTES) | Response block address |
| rsp_squashed | input | 1 | Response belongs to a squashed request |
| rsp_data | input | 8*BLK_BYTES | Returned block |
| sq_valid | input | 1 | Squash of one waiting instruction |
| sq_asid | input | ASID_W | Squash identifier |
| sq_addr | input | ADDR_W | Squash byte address |
| buf_sq_blk | output | ADDR_W-log2(BLK_BYTES) | Block looked up in buffered table for the squash |
| buf_sq_hit | input | 1 | Buffered table holds (sq_asid, buf_sq_blk) |
| buf_dec | output | 1 | Decrement waiting count of that buffered block |
| fill_valid | input | 1 | Consumer asks for a pending block |
| fill_asid | input | ASID_W | Fill identifier |
| fill_addr | input | ADDR_W | Fill byte address |
| fill_ok | output | 1 | Block handed over and entry freed |
| fill_data | output | 8*BLK_BYTES | Handed-over block |
| fill_cnt | output | CNT_W | Instructions still waiting after this one |

## Verification
Request outcomes (`req_ready`, `req_merged`, `buf_inc`, `mem_rd_*`), `buf_dec` and `fill_ok`/`fill_data`/`fill_cnt` are combinational on the inputs of the same cycle. The bench samples them one time unit after it drives inputs, well before the rising edge. Count changes, allocation, validation by a response and freeing by squash or fill take effect at the next rising edge and show up only in the outputs of the following cycle. The behavioural model therefore computes expected outputs from its state before the edge and commits its updates right after that edge. Assertions cover the same-cycle exclusions, such as no read on refusal or merge and alignment of the read address, as well as the one-cycle gap between allocation and validity.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
    // Outcome of the request port in one cycle
    typedef enum logic [1:0] {
        REQ_IDLE = 2'd0,
        REQ_PEND = 2'd1,
        REQ_BUF  = 2'd2,
        REQ_MISS = 2'd3
    } req_kind_e;
endpackage

// File: rtl/fmm_lowest.sv
module fmm_lowest #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |bits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/fmm_match.sv
module fmm_match #(
    parameter int N  = 4,
    parameter int KW = 35,
    parameter int IW = 2
) (
    input  logic [N-1:0]         en,
    input  logic [N-1:0][KW-1:0] keys,
    input  logic [KW-1:0]        key,
    output logic                 hit,
    output logic [IW-1:0]        idx
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = en[g] && (keys[g] == key);
    end

    fmm_lowest #(.N(N), .IW(IW)) u_pick (.bits(eq), .any(hit), .idx(idx));
endmodule

// File: rtl/fetch_miss_merge.sv
module fetch_miss_merge
    import fmm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ASID_W    = 8,
    parameter int DEPTH     = 4,
    parameter int BLK_BYTES = 32,
    parameter int CNT_W     = 4,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int BLK_W    = ADDR_W - OFF_W,
    localparam int DATA_W   = 8 * BLK_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_merged,
    output logic [BLK_W-1:0]  buf_req_blk,
    input  logic              buf_req_hit,
    output logic              buf_inc,
    output logic              mem_rd_valid,
    output logic [ASID_W-1:0] mem_rd_asid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              rsp_valid,
    input  logic [ASID_W-1:0] rsp_asid,
    input  logic [BLK_W-1:0]  rsp_blk,
    input  logic              rsp_squashed,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              sq_valid,
    input  logic [ASID_W-1:0] sq_asid,
    input  logic [ADDR_W-1:0] sq_addr,
    output logic [BLK_W-1:0]  buf_sq_blk,
    input  logic              buf_sq_hit,
    output logic              buf_dec,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              fill_ok,
    output logic [DATA_W-1:0] fill_data,
    output logic [CNT_W-1:0]  fill_cnt
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int KEY_W = ASID_W + BLK_W;

    typedef struct packed {
        logic              alloc;
        logic              vld;
        logic [ASID_W-1:0] asid;
        logic [BLK_W-1:0]  blk;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
    } st_t;

    st_t state_q, state_d;

    logic [BLK_W-1:0] req_blk, fill_blk;
    assign req_blk     = BLK_W'(req_addr >> OFF_W);
    assign fill_blk    = BLK_W'(fill_addr >> OFF_W);
    assign buf_req_blk = req_blk;
    assign buf_sq_blk  = BLK_W'(sq_addr >> OFF_W);

    logic [DEPTH-1:0]            alloc_v, free_v;
    logic [DEPTH-1:0][KEY_W-1:0] key_v;

    for (genvar g = 0; g < DEPTH; g++) begin : g_keys
        assign alloc_v[g] = state_q.ent[g].alloc;
        assign free_v[g]  = ~state_q.ent[g].alloc;
        assign key_v[g]   = {state_q.ent[g].asid, state_q.ent[g].blk};
    end

    logic             req_hit, rsp_hit, sq_hit, fill_hit, free_any;
    logic [IDX_W-1:0] req_idx, rsp_idx, sq_idx, fill_idx, free_idx;

    fmm_match #(.N(DEPTH), .KW(KEY_W), .IW(IDX_W)) u_req_m (
        .en(alloc_v), .keys(key_v), .key({req_asid, req_blk}),
        .hit(req_hit), .idx(req_idx));
    fmm_match #(.N(DEPTH), .KW(KEY_W), .IW(IDX_W)) u_rsp_m (
        .en(alloc_v), .keys(key_v), .key({rsp_asid, rsp_blk}),
        .hit(rsp_hit), .idx(rsp_idx));
    fmm_match #(.N(DEPTH), .KW(KEY_W), .IW(IDX_W)) u_sq_m (
        .en(alloc_v), .keys(key_v), .key({sq_asid, buf_sq_blk}),
        .hit(sq_hit), .idx(sq_idx));
    fmm_match #(.N(DEPTH), .KW(KEY_W), .IW(IDX_W)) u_fill_m (
        .en(alloc_v), .keys(key_v), .key({fill_asid, fill_blk}),
        .hit(fill_hit), .idx(fill_idx));
    fmm_lowest #(.N(DEPTH), .IW(IDX_W)) u_free (
        .bits(free_v), .any(free_any), .idx(free_idx));

    req_kind_e kind;
    logic      sq_pend;
    logic      inc_i, dec_i;

    always_comb begin
        kind = REQ_IDLE;
        if (req_valid) begin
            if (req_hit)          kind = REQ_PEND;
            else if (free_any)    kind = buf_req_hit ? REQ_BUF : REQ_MISS;
        end
        req_ready    = req_hit | free_any;
        req_merged   = (kind == REQ_PEND) || (kind == REQ_BUF);
        buf_inc      = (kind == REQ_BUF);
        mem_rd_valid = (kind == REQ_MISS);
        mem_rd_asid  = req_asid;
        mem_rd_addr  = {req_blk, {OFF_W{1'b0}}};

        buf_dec = sq_valid & buf_sq_hit;
        sq_pend = sq_valid & ~buf_sq_hit & sq_hit;

        state_d = state_q;
        inc_i   = 1'b0;
        dec_i   = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            inc_i = (kind == REQ_PEND) && (req_idx == IDX_W'(i));
            dec_i = sq_pend && (sq_idx == IDX_W'(i));
            state_d.ent[i].cnt = state_q.ent[i].cnt + CNT_W'(inc_i) - CNT_W'(dec_i);
            if (rsp_valid && !rsp_squashed && rsp_hit && (rsp_idx == IDX_W'(i))) begin
                state_d.ent[i].vld  = 1'b1;
                state_d.ent[i].data = rsp_data;
            end
            if (state_d.ent[i].cnt == '0) begin
                state_d.ent[i].alloc = 1'b0;
                state_d.ent[i].vld   = 1'b0;
            end
        end

        fill_data = state_q.ent[fill_idx].data;
        fill_cnt  = state_d.ent[fill_idx].cnt - CNT_W'(1);
        fill_ok   = fill_valid && fill_hit && state_q.ent[fill_idx].vld
                    && (state_d.ent[fill_idx].cnt != '0);
        if (fill_ok) begin
            state_d.ent[fill_idx].alloc = 1'b0;
            state_d.ent[fill_idx].vld   = 1'b0;
            state_d.ent[fill_idx].cnt   = '0;
        end

        if (kind == REQ_MISS) begin
            state_d.ent[free_idx].alloc = 1'b1;
            state_d.ent[free_idx].vld   = 1'b0;
            state_d.ent[free_idx].asid  = req_asid;
            state_d.ent[free_idx].blk   = req_blk;
            state_d.ent[free_idx].cnt   = CNT_W'(1);
            state_d.ent[free_idx].data  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/fmm_chk.sv
module fmm_chk #(
    parameter int ADDR_W = 32,
    parameter int ASID_W = 8,
    parameter int OFF_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_merged,
    input logic              buf_req_hit,
    input logic              buf_inc,
    input logic              mem_rd_valid,
    input logic [ASID_W-1:0] mem_rd_asid,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              fill_valid,
    input logic [ASID_W-1:0] fill_asid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              fill_ok
);
    assert_refuse_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |-> (!mem_rd_valid && !buf_inc && !req_merged));

    assert_merge_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_merged |-> (req_ready && !mem_rd_valid));

    assert_buf_inc_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_inc |-> (buf_req_hit && req_merged && !mem_rd_valid));

    assert_read_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[OFF_W-1:0] == '0));

    assert_new_miss_not_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !(fill_ok && fill_asid == $past(mem_rd_asid)
                           && (fill_addr >> OFF_W) == ($past(mem_rd_addr) >> OFF_W)));

    assert_fill_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok |=> !(fill_ok && fill_asid == $past(fill_asid)
                      && (fill_addr >> OFF_W) == ($past(fill_addr) >> OFF_W)));

    assert_fill_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok |-> fill_valid);
endmodule

bind fetch_miss_merge fmm_chk #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_merged(req_merged), .buf_req_hit(buf_req_hit), .buf_inc(buf_inc),
    .mem_rd_valid(mem_rd_valid), .mem_rd_asid(mem_rd_asid), .mem_rd_addr(mem_rd_addr),
    .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_addr(fill_addr),
    .fill_ok(fill_ok));

// File: tb/sim_fetch_miss_merge.sv
module sim_fetch_miss_merge;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32, ASID_W = 8, DEPTH = 4, BLK_BYTES = 32, CNT_W = 4;
    localparam int OFF_W = 5, BLK_W = ADDR_W - OFF_W, DATA_W = 8 * BLK_BYTES;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid, req_ready, req_merged, buf_req_hit, buf_inc;
    logic [ASID_W-1:0] req_asid, mem_rd_asid, rsp_asid, sq_asid, fill_asid;
    logic [ADDR_W-1:0] req_addr, mem_rd_addr, sq_addr, fill_addr;
    logic [BLK_W-1:0]  buf_req_blk, buf_sq_blk, rsp_blk;
    logic mem_rd_valid, rsp_valid, rsp_squashed, sq_valid, buf_sq_hit, buf_dec;
    logic fill_valid, fill_ok;
    logic [DATA_W-1:0] rsp_data, fill_data;
    logic [CNT_W-1:0]  fill_cnt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fetch_miss_merge #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .DEPTH(DEPTH),
                       .BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)) u0 (.*);

    int n_checks = 0, n_errors = 0;
    bit done = 0;
    bit last_rd, last_fok, last_inc, last_ready;

    // behavioural model: list of pending misses
    int          m_asid[$];
    longint      m_blk[$];
    int          m_cnt[$];
    bit          m_vld[$];
    logic [DATA_W-1:0] m_data[$];

    function automatic int find(int a, longint b);
        for (int i = 0; i < m_asid.size(); i++)
            if (m_asid[i] == a && m_blk[i] == b) return i;
        return -1;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_asid = '0; req_addr = '0; buf_req_hit = 0;
        rsp_valid = 0; rsp_asid = '0; rsp_blk = '0; rsp_squashed = 0; rsp_data = '0;
        sq_valid = 0; sq_asid = '0; sq_addr = '0; buf_sq_hit = 0;
        fill_valid = 0; fill_asid = '0; fill_addr = '0;
    endtask

    // one clock: compare outputs with model, then commit model at the edge
    task automatic cyc();
        int ph, sh, rh, fh;
        bit room, e_ready, e_merged, e_rd, e_inc, e_dec, e_fok;
        int ncnt[$];
        #1;
        ph = find(req_asid, longint'(req_addr >> OFF_W));
        room = m_asid.size() < DEPTH;
        e_ready  = (ph >= 0) || room;
        e_merged = req_valid && (ph >= 0 || (room && buf_req_hit));
        e_rd     = req_valid && ph < 0 && room && !buf_req_hit;
        e_inc    = req_valid && ph < 0 && room && buf_req_hit;
        e_dec    = sq_valid && buf_sq_hit;
        sh = (sq_valid && !buf_sq_hit) ? find(sq_asid, longint'(sq_addr >> OFF_W)) : -1;
        rh = (rsp_valid && !rsp_squashed) ? find(rsp_asid, longint'(rsp_blk)) : -1;
        fh = fill_valid ? find(fill_asid, longint'(fill_addr >> OFF_W)) : -1;
        ncnt = {};
        for (int i = 0; i < m_asid.size(); i++)
            ncnt.push_back(m_cnt[i] + ((req_valid && ph == i) ? 1 : 0) - ((sh == i) ? 1 : 0));
        e_fok = (fh >= 0) && m_vld[fh] && ncnt[fh] > 0;

        chk(req_ready == e_ready, "R4 req_ready", req_ready, e_ready);
        chk(req_merged == e_merged, "R2 req_merged", req_merged, e_merged);
        chk(mem_rd_valid == e_rd, "R5 mem_rd_valid", mem_rd_valid, e_rd);
        chk(buf_inc == e_inc, "R3 buf_inc", buf_inc, e_inc);
        chk(buf_dec == e_dec, "R8 buf_dec", buf_dec, e_dec);
        chk(fill_ok == e_fok, "R9 fill_ok", fill_ok, e_fok);
        if (e_rd) begin
            chk(mem_rd_addr == ((req_addr >> OFF_W) << OFF_W), "R5 mem_rd_addr",
                mem_rd_addr, (req_addr >> OFF_W) << OFF_W);
            chk(mem_rd_asid == req_asid, "R5 mem_rd_asid", mem_rd_asid, req_asid);
        end
        if (e_fok) begin
            chk(fill_cnt == CNT_W'(ncnt[fh] - 1), "R9 fill_cnt", fill_cnt, ncnt[fh] - 1);
            n_checks++;
            if (fill_data !== m_data[fh]) begin
                n_errors++;
                $display("FAIL R6 fill_data: actual=%h expected=%h", fill_data, m_data[fh]);
            end
        end
        last_rd = mem_rd_valid; last_fok = fill_ok; last_inc = buf_inc; last_ready = req_ready;

        @(posedge clk);
        for (int i = 0; i < m_asid.size(); i++) m_cnt[i] = ncnt[i];
        if (rh >= 0) begin m_vld[rh] = 1; m_data[rh] = rsp_data; end
        for (int i = m_asid.size() - 1; i >= 0; i--) begin
            if ((e_fok && i == fh) || m_cnt[i] == 0) begin
                m_asid.delete(i); m_blk.delete(i); m_cnt.delete(i);
                m_vld.delete(i); m_data.delete(i);
            end
        end
        if (e_rd) begin
            m_asid.push_back(req_asid); m_blk.push_back(longint'(req_addr >> OFF_W));
            m_cnt.push_back(1); m_vld.push_back(0); m_data.push_back('0);
        end
        @(negedge clk);
    endtask

    task automatic req(int a, int addr, bit bhit);
        idle(); req_valid = 1; req_asid = ASID_W'(a); req_addr = ADDR_W'(addr);
        buf_req_hit = bhit; cyc();
    endtask
    task automatic rsp(int a, int addr, bit sqd, logic [DATA_W-1:0] d);
        idle(); rsp_valid = 1; rsp_asid = ASID_W'(a); rsp_blk = BLK_W'(addr >> OFF_W);
        rsp_squashed = sqd; rsp_data = d; cyc();
    endtask
    task automatic squash(int a, int addr, bit bhit);
        idle(); sq_valid = 1; sq_asid = ASID_W'(a); sq_addr = ADDR_W'(addr);
        buf_sq_hit = bhit; cyc();
    endtask
    task automatic fill(int a, int addr);
        idle(); fill_valid = 1; fill_asid = ASID_W'(a); fill_addr = ADDR_W'(addr); cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R10: reset state
        chk(req_ready == 1, "R10 req_ready after reset", req_ready, 1);
        chk(fill_ok == 0, "R10 fill_ok after reset", fill_ok, 0);
        chk(mem_rd_valid == 0, "R10 no read after reset", mem_rd_valid, 0);
        @(negedge clk);

        req(1, 'h1004, 0);                    // miss R5
        req(1, 'h101C, 0);                    // same block merges R1/R2
        chk(last_rd == 0, "R1 same block other offset merged", last_rd, 0);
        req(2, 'h1000, 0);                    // same block other id: miss R1
        chk(last_rd == 1, "R1 other identifier is a miss", last_rd, 1);
        fill(1, 'h1000);                      // not yet valid R5
        chk(last_fok == 0, "R5 new entry not valid", last_fok, 0);
        rsp(1, 'h1000, 1, {8{32'hDEADBEEF}}); // squashed response R7
        fill(1, 'h1008);
        chk(last_fok == 0, "R7 squashed response dropped", last_fok, 0);
        rsp(1, 'h1000, 0, {8{32'h0A1B2C3D}}); // R6
        fill(1, 'h1010);                      // R9: cnt 2 -> fill_cnt 1
        chk(last_fok == 1, "R6 stored block handed over", last_fok, 1);
        req(3, 'h2000, 1);                    // buffered hit R3
        chk(last_inc == 1, "R3 buffered hit increments", last_inc, 1);
        req(1, 'h3000, 0);
        req(1, 'h4000, 0);
        req(1, 'h5000, 0);
        req(4, 'h6000, 0);                    // four pending now: refused R4
        chk(last_ready == 0, "R4 full refuses", last_ready, 0);
        req(3, 'h2000, 1);                    // buffer not consulted at capacity R3/R4
        chk(last_inc == 0, "R3 buffer skipped when full", last_inc, 0);
        req(1, 'h3004, 0);                    // merge while full R2
        squash(3, 'h2000, 1);                 // R8 buffered squash
        squash(1, 'h4000, 0);                 // R8 count 1 -> freed
        req(4, 'h6000, 0);                    // slot available again
        chk(last_rd == 1, "R8 squash freed a slot", last_rd, 1);
        squash(1, 'h3000, 0);                 // cnt 2 -> 1, stays
        req(5, 'h7000, 0);
        chk(last_ready == 0, "R8 nonzero count keeps entry", last_ready, 0);
        // simultaneous merge and squash on one entry
        idle(); req_valid = 1; req_asid = 1; req_addr = 'h5000;
        sq_valid = 1; sq_asid = 1; sq_addr = 'h5010; cyc();
        rsp(1, 'h5000, 0, {4{64'h1122334455667788}});
        fill(1, 'h5000);                      // cnt 1 -> fill_cnt 0
        rsp(2, 'h1000, 0, {8{32'h55AA55AA}});
        // response and fill in the same cycle on different entries
        idle(); rsp_valid = 1; rsp_asid = 1; rsp_blk = BLK_W'('h3000 >> OFF_W);
        rsp_data = {8{32'h0F0F0F0F}}; fill_valid = 1; fill_asid = 2; fill_addr = 'h1000; cyc();
        fill(1, 'h3000);
        idle(); cyc(); cyc();

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule